// File: doc/BRIEF.md
# Trip Supervision with Transient Detection

This block sits between the zone-1 elements of a numerical distance relay and the breaker. It watches the three phase voltages sample by sample, and it holds back a zone-1 trip while the voltage transformer secondary still carries a slow transient, but only when the source-to-line impedance ratio is flagged as high. Each phase feeds a moving-average filter spanning one power cycle (12 samples at 600 Hz on a 50 Hz system). A clean fundamental averages to nearly zero over that window, so a filter output outside a small symmetric band shows a transient residue. Any phase outside the band raises a signal-unfit flag.

The six zone-1 requests (three ground loops, three phase-to-phase loops) are ORed and must be seen on consecutive sample strobes before the trip counts as qualified. A qualified trip is forwarded unless the signal-unfit flag and the SIR-high input are both set. The block time therefore tracks how long the residue stays out of the band, not a fixed timer. A forwarded trip sets a latched breaker command that only reset or an explicit clear releases.

Top module: `trip_supervisor`

## Requirements
- R1: For each phase, the block keeps the sum of that phase's last WIN_LEN samples (default 12). The phase is fit when −LIMIT·WIN_LEN ≤ sum ≤ +LIMIT·WIN_LEN, band edges inclusive (default LIMIT = 1, so the sum must lie in [−12, +12]). The sum is compared directly, with no division.
- R2: `sig_unfit` is high when at least one of the three phases is not fit.
- R3: `sig_unfit` stays high from reset until WIN_LEN sample strobes have been received.
- R4: The trip request is the OR of the six bits `zone_gnd[2:0]` and `zone_ph[2:0]`. Any single bit counts as a request.
- R5: A request is qualified once it has been present on SEC_COUNT consecutive strobes (default 2). A strobe without any request restarts the count. The qualification shows on the cycle after the qualifying strobe and holds until the next strobe.
- R6: `trip_fwd` is the qualified trip, forced low while `sig_unfit` and `sir_high` are both high.
- R7: With `sir_high` low, a qualified trip reaches `trip_fwd` whether or not `sig_unfit` is set.
- R8: The block ends on its own when the residue of every phase is back inside the band. A request that is still present is then forwarded with no fixed delay.
- R9: `brk_trip` goes high on the cycle after `trip_fwd` is high, and it stays high after `trip_fwd` falls.
- R10: `latch_clr` clears `brk_trip` on the next cycle, and it wins over a simultaneous set. `rst` (synchronous, active high) clears all state.
- R11: Samples and requests presented while `smp_valid` is low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample set |
| smp_a | input | SAMPLE_W | Signed voltage sample, phase A |
| smp_b | input | SAMPLE_W | Signed voltage sample, phase B |
| smp_c | input | SAMPLE_W | Signed voltage sample, phase C |
| zone_gnd | input | 3 | Zone-1 ground loop trip requests |
| zone_ph | input | 3 | Zone-1 phase-to-phase loop trip requests |
| sir_high | input | 1 | Source-to-line impedance ratio above 5 |
| latch_clr | input | 1 | Clear for the latched breaker command |
| sig_unfit | output | 1 | Voltage residue outside band on any phase |
| trip_fwd | output | 1 | Qualified trip passed by the supervision |
| brk_trip | output | 1 | Latched breaker trip command |

## Verification
The bench builds the block with its defaults: 16-bit samples, a 12-sample window, LIMIT 1 and a security count of 2. It drives a 12-point symmetric waveform whose window sum is exactly zero, so a DC offset of ±1 places a phase on the inclusive band edge and ±2 places it just outside. A single offset burst then shows the block stretching for exactly as many strobes as the burst needs to leave the 12-sample window. A security count of 2 lets every one of the six request bits be shown both short of and at qualification within a few strobes.

// File: rtl/trip_sup_pkg.sv
package trip_sup_pkg;

    typedef enum logic [1:0] {
        BAND_BELOW  = 2'd0,
        BAND_INSIDE = 2'd1,
        BAND_ABOVE  = 2'd2
    } band_e;

    typedef struct packed {
        logic [2:0] gnd;
        logic [2:0] ph;
    } zone_req_t;

    function automatic band_e classify(input logic signed [31:0] total,
                                       input logic signed [31:0] bound);
        if (total > bound)
            return BAND_ABOVE;
        else if (total < -bound)
            return BAND_BELOW;
        return BAND_INSIDE;
    endfunction

    function automatic logic any_request(input zone_req_t r);
        return (|r.gnd) | (|r.ph);
    endfunction

endpackage

// File: rtl/residue_window.sv
module residue_window
    import trip_sup_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int WIN_LEN  = 12,
    parameter int LIMIT    = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp,
    output logic                       unfit
);
    localparam int SUM_W = SAMPLE_W + $clog2(WIN_LEN) + 1;
    localparam int CNT_W = $clog2(WIN_LEN + 1);
    localparam int BOUND = LIMIT * WIN_LEN;
    localparam logic signed [SUM_W-1:0] SUM_MAX = SUM_W'(WIN_LEN) <<< (SAMPLE_W - 1);

    logic signed [SAMPLE_W-1:0] dly [WIN_LEN];
    logic signed [SUM_W-1:0]    sum;
    logic [CNT_W-1:0]           fill;
    logic signed [SUM_W-1:0]    new_ext, old_ext;
    band_e                      band;

    assign new_ext = {{(SUM_W-SAMPLE_W){smp[SAMPLE_W-1]}}, smp};
    assign old_ext = {{(SUM_W-SAMPLE_W){dly[WIN_LEN-1][SAMPLE_W-1]}}, dly[WIN_LEN-1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            sum  <= '0;
            fill <= '0;
            for (int i = 0; i < WIN_LEN; i++) dly[i] <= '0;
        end else if (smp_valid) begin
            dly[0] <= smp;
            for (int i = 1; i < WIN_LEN; i++) dly[i] <= dly[i-1];
            sum <= sum + new_ext - old_ext;
            if (fill != CNT_W'(WIN_LEN)) fill <= fill + 1'b1;
        end
    end

    assign band  = classify(32'(sum), 32'(BOUND));
    assign unfit = (fill != CNT_W'(WIN_LEN)) || (band != BAND_INSIDE);

    // R1
    sum_range_chk: assert property (@(posedge clk) disable iff (rst)
        (sum <= SUM_MAX) && (sum >= -SUM_MAX));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(sum) && $stable(fill));

endmodule

// File: rtl/trip_security.sv
module trip_security #(
    parameter int SEC_COUNT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic smp_valid,
    input  logic req,
    output logic qualified
);
    localparam int CW = $clog2(SEC_COUNT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (smp_valid) begin
            if (!req)
                cnt <= '0;
            else if (cnt != CW'(SEC_COUNT))
                cnt <= cnt + 1'b1;
        end
    end

    assign qualified = (cnt == CW'(SEC_COUNT));

    // R5
    qual_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(qualified) |-> $past(smp_valid) && $past(req));

endmodule

// File: rtl/trip_hold.sv
module trip_hold (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic held
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            held <= 1'b0;
        else if (set)
            held <= 1'b1;
    end

    // R9
    latch_keep_chk: assert property (@(posedge clk) disable iff (rst)
        held && !clr |=> held);

    // R10
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !held);

endmodule

// File: rtl/trip_supervisor.sv
module trip_supervisor
    import trip_sup_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int WIN_LEN   = 12,
    parameter int LIMIT     = 1,
    parameter int SEC_COUNT = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       smp_valid,
    input  logic signed [SAMPLE_W-1:0] smp_a,
    input  logic signed [SAMPLE_W-1:0] smp_b,
    input  logic signed [SAMPLE_W-1:0] smp_c,
    input  logic [2:0]                 zone_gnd,
    input  logic [2:0]                 zone_ph,
    input  logic                       sir_high,
    input  logic                       latch_clr,
    output logic                       sig_unfit,
    output logic                       trip_fwd,
    output logic                       brk_trip
);
    localparam int PHASES = 3;

    logic signed [SAMPLE_W-1:0] smp_arr [PHASES];
    logic [PHASES-1:0]          unfit_vec;
    zone_req_t                  req;
    logic                       qualified;

    assign smp_arr[0] = smp_a;
    assign smp_arr[1] = smp_b;
    assign smp_arr[2] = smp_c;

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        residue_window #(
            .SAMPLE_W(SAMPLE_W),
            .WIN_LEN (WIN_LEN),
            .LIMIT   (LIMIT)
        ) u_win (
            .clk      (clk),
            .rst      (rst),
            .smp_valid(smp_valid),
            .smp      (smp_arr[p]),
            .unfit    (unfit_vec[p])
        );
    end

    assign sig_unfit = |unfit_vec;

    assign req.gnd = zone_gnd;
    assign req.ph  = zone_ph;

    trip_security #(.SEC_COUNT(SEC_COUNT)) u_sec (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .req      (any_request(req)),
        .qualified(qualified)
    );

    assign trip_fwd = qualified && !(sig_unfit && sir_high);

    trip_hold u_hold (
        .clk (clk),
        .rst (rst),
        .set (trip_fwd),
        .clr (latch_clr),
        .held(brk_trip)
    );

    // R6
    no_blocked_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_trip) |-> !($past(sig_unfit) && $past(sir_high)));

    // R9
    set_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(brk_trip) |-> $past(trip_fwd));

endmodule

// File: tb/trip_supervisor_tb_top.sv
module trip_supervisor_tb_top;

    localparam int W = 16;
    localparam int N = 12;
    localparam int BOUND = 12;
    localparam int SEC = 2;

    logic clk = 1'b0;
    logic rst;
    logic smp_valid;
    logic signed [W-1:0] smp_a, smp_b, smp_c;
    logic [2:0] zone_gnd, zone_ph;
    logic sir_high, latch_clr;
    logic sig_unfit, trip_fwd, brk_trip;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int wave [12] = '{100, 87, 50, 0, -50, -87, -100, -87, -50, 0, 50, 87};
    int hist [3][12];
    int fill_m = 0;
    int cnt_m = 0;
    int widx = 0;

    always #10 clk = ~clk;

    trip_supervisor #(.SAMPLE_W(W), .WIN_LEN(N), .LIMIT(1), .SEC_COUNT(SEC)) dut_i (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_a(smp_a), .smp_b(smp_b), .smp_c(smp_c),
        .zone_gnd(zone_gnd), .zone_ph(zone_ph),
        .sir_high(sir_high), .latch_clr(latch_clr),
        .sig_unfit(sig_unfit), .trip_fwd(trip_fwd), .brk_trip(brk_trip)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic model_unfit();
        if (fill_m < N) return 1'b1;
        for (int p = 0; p < 3; p++) begin
            int s = 0;
            for (int k = 0; k < N; k++) s += hist[p][k];
            if (s > BOUND || s < -BOUND) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic logic model_fwd();
        return (cnt_m == SEC) && !(model_unfit() && sir_high);
    endfunction

    // one strobe; offsets added to the clean wave; checks unfit and forward after it
    task automatic push(input int oa, input int ob, input int oc,
                        input logic [2:0] g, input logic [2:0] p, input string tag);
        int v [3];
        @(negedge clk);
        for (int j = 0; j < 3; j++) v[j] = wave[(widx + 4*j) % 12];
        v[0] += oa; v[1] += ob; v[2] += oc;
        smp_a = W'(v[0]); smp_b = W'(v[1]); smp_c = W'(v[2]);
        zone_gnd = g; zone_ph = p; smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
        widx = (widx + 1) % 12;
        for (int j = 0; j < 3; j++) begin
            for (int k = N-1; k > 0; k--) hist[j][k] = hist[j][k-1];
            hist[j][0] = v[j];
        end
        if (fill_m < N) fill_m++;
        if ((g | p) == 3'b000) cnt_m = 0;
        else if (cnt_m < SEC) cnt_m++;
        chk(sig_unfit, model_unfit(), {tag, " sig_unfit"});
        chk(trip_fwd, model_fwd(), {tag, " trip_fwd"});
    endtask

    task automatic clean(input int n, input string tag);
        for (int i = 0; i < n; i++) push(0, 0, 0, 3'b000, 3'b000, tag);
    endtask

    task automatic t_reset();
        rst = 1'b1; smp_valid = 0; smp_a = 0; smp_b = 0; smp_c = 0;
        zone_gnd = 0; zone_ph = 0; sir_high = 0; latch_clr = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(sig_unfit, 1'b1, "R3 reset sig_unfit");
        chk(trip_fwd, 1'b0, "R10 reset trip_fwd");
        chk(brk_trip, 1'b0, "R10 reset brk_trip");
    endtask

    task automatic t_fill();
        clean(11, "R3 fill");
        chk(sig_unfit, 1'b1, "R3 before 12th");
        clean(1, "R1 twelfth");
        chk(sig_unfit, 1'b0, "R3 primed clean");
    endtask

    task automatic t_band_edges();
        for (int i = 0; i < 12; i++) push(1, 0, 0, 0, 0, "R1 plus1");
        chk(sig_unfit, 1'b0, "R1 edge +12 inside");
        for (int i = 0; i < 12; i++) push(2, 0, 0, 0, 0, "R1 plus2");
        chk(sig_unfit, 1'b1, "R1 +24 outside");
        for (int i = 0; i < 12; i++) push(-1, 0, 0, 0, 0, "R1 minus1");
        chk(sig_unfit, 1'b0, "R1 edge -12 inside");
        for (int i = 0; i < 12; i++) push(-2, 0, 0, 0, 0, "R1 minus2");
        chk(sig_unfit, 1'b1, "R1 -24 outside");
        clean(12, "R1 flush");
    endtask

    task automatic t_or_phases();
        push(0, 0, 20, 0, 0, "R2 phase c");
        chk(sig_unfit, 1'b1, "R2 phase c alone");
        clean(12, "R2 flush c");
        push(0, -20, 0, 0, 0, "R2 phase b");
        chk(sig_unfit, 1'b1, "R2 phase b alone");
        clean(12, "R2 flush b");
        chk(sig_unfit, 1'b0, "R2 all clean");
    endtask

    task automatic t_idle_ignored();
        @(negedge clk);
        smp_a = 16'sd3000; smp_b = -16'sd3000; smp_c = 16'sd3000;
        zone_gnd = 3'b111; zone_ph = 3'b111;
        repeat (5) @(negedge clk);
        chk(sig_unfit, 1'b0, "R11 samples without strobe");
        chk(trip_fwd, 1'b0, "R11 requests without strobe");
        chk(brk_trip, 1'b0, "R11 no latch");
        zone_gnd = 0; zone_ph = 0;
    endtask

    task automatic t_each_request();
        for (int b = 0; b < 6; b++) begin
            logic [2:0] g, p;
            g = (b < 3) ? 3'(1 << b) : 3'b000;
            p = (b >= 3) ? 3'(1 << (b-3)) : 3'b000;
            push(0, 0, 0, g, p, "R5 first strobe");
            chk(trip_fwd, 1'b0, "R5 one strobe short");
            push(0, 0, 0, 0, 0, "R5 gap");
            push(0, 0, 0, g, p, "R5 restart");
            chk(trip_fwd, 1'b0, "R5 restart after gap");
            push(0, 0, 0, g, p, "R4 second strobe");
            chk(trip_fwd, 1'b1, "R4 single bit qualifies");
            @(negedge clk);
            chk(brk_trip, 1'b1, "R9 latch set");
            push(0, 0, 0, 0, 0, "R9 drop");
            @(negedge clk);
            chk(brk_trip, 1'b1, "R9 holds after drop");
            latch_clr = 1'b1;
            @(negedge clk);
            latch_clr = 1'b0;
            chk(brk_trip, 1'b0, "R10 clear");
        end
    endtask

    task automatic t_adaptive_block();
        sir_high = 1'b1;
        for (int i = 0; i < 5; i++) push(30, 0, 0, 3'b001, 3'b000, "R6 transient");
        chk(trip_fwd, 1'b0, "R6 blocked");
        for (int i = 0; i < 11; i++) push(0, 0, 0, 3'b001, 3'b000, "R8 residue");
        chk(trip_fwd, 1'b0, "R8 still in window");
        @(negedge clk);
        chk(brk_trip, 1'b0, "R6 no latch while blocked");
        push(0, 0, 0, 3'b001, 3'b000, "R8 release");
        chk(sig_unfit, 1'b0, "R8 residue gone");
        chk(trip_fwd, 1'b1, "R8 forwarded");
        @(negedge clk);
        chk(brk_trip, 1'b1, "R8 latch after release");
        latch_clr = 1'b1;
        @(negedge clk);
        latch_clr = 1'b0;
        chk(brk_trip, 1'b0, "R10 clear wins over set");
        @(negedge clk);
        chk(brk_trip, 1'b1, "R10 reset by held trip");
        push(0, 0, 0, 0, 0, "R10 drop");
        latch_clr = 1'b1;
        @(negedge clk);
        latch_clr = 1'b0;
        @(negedge clk);
        chk(brk_trip, 1'b0, "R10 stays clear");
        sir_high = 1'b0;
    endtask

    task automatic t_sir_low();
        sir_high = 1'b0;
        push(40, 0, 0, 3'b000, 3'b010, "R7 first");
        push(40, 0, 0, 3'b000, 3'b010, "R7 second");
        chk(sig_unfit, 1'b1, "R7 unfit");
        chk(trip_fwd, 1'b1, "R7 passes with sir low");
        sir_high = 1'b1;
        @(negedge clk);
        chk(trip_fwd, 1'b0, "R6 block on sir rise");
        sir_high = 1'b0;
        clean(12, "R7 flush");
        latch_clr = 1'b1;
        @(negedge clk);
        latch_clr = 1'b0;
    endtask

    initial begin
        for (int j = 0; j < 3; j++)
            for (int k = 0; k < 12; k++) hist[j][k] = 0;
        t_reset();
        t_fill();
        t_band_edges();
        t_or_phases();
        t_idle_ignored();
        t_each_request();
        t_adaptive_block();
        t_sir_low();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule